// File: doc/BRIEF.md
# Dual Circular Address Generator

This block produces two data addresses in the same cycle from a shared file of register sets. Each set holds an index, a step (modify), a buffer length and a buffer base. Each generator reads the index of the set it selects and presents it as its address. If post-update is requested, it writes back the index advanced by a step. The step comes either from the set's own modify register or from an immediate supplied with the request.

When a set's length is nonzero, the advanced index stays inside the window that starts at the base and spans the length. A result at or above the window's end is pulled back by one length. A result below the base is pushed forward by one length. A zero length gives plain linear stepping.

Registers are loaded through a single write port that names a set and one of the four register kinds. Memory access itself is not part of the block. Two address units sit beside a register file. Parameters set the address width, the number of sets and whether the wrap logic is built.

Top module: `dual_circ_agen`

## Requirements
- R1: After a synchronous active-low reset, every register of every set is zero, so both addresses and both next-index outputs read 0 while no write has occurred.
- R2: Each generator independently drives its address output, in the same cycle, with the current index of the set it selects. The two generators may select different sets.
- R3: Each next-index output shows the selected index plus the step, with the sum taken modulo 2^AW. The step is the set's modify register when the immediate flag is 0, or the request's immediate (two's complement) when it is 1. A valid request with post-update set stores this value into that set's index at the next clock edge.
- R4: With a nonzero length, a sum at or above base plus length (unsigned) has the length subtracted.
- R5: With a nonzero length, a sum below the base (unsigned) has the length added.
- R6: With a length of zero, the sum is used unchanged whatever the base holds.
- R7: An index changes only when a generator presents a valid request with post-update set, or when the index is written. A request with post-update clear, or a post-update with valid low, leaves it unchanged.
- R8: If both generators post-update the same set in one cycle, the index takes generator 0's result.
- R9: The write port selects the register with wr_kind: 0 index, 1 modify, 2 length, 3 base. A write takes effect at the next clock edge, so it does not change the address or next-index outputs during its own cycle. A write to an index overrides any post-update of that index in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req0_valid | input | 1 | Generator 0 request valid |
| req0_set | input | SW | Generator 0 set select |
| req0_use_imm | input | 1 | Generator 0 takes its step from req0_imm |
| req0_imm | input | AW | Generator 0 immediate step (two's complement) |
| req0_postmod | input | 1 | Generator 0 writes back the advanced index |
| req1_valid | input | 1 | Generator 1 request valid |
| req1_set | input | SW | Generator 1 set select |
| req1_use_imm | input | 1 | Generator 1 takes its step from req1_imm |
| req1_imm | input | AW | Generator 1 immediate step (two's complement) |
| req1_postmod | input | 1 | Generator 1 writes back the advanced index |
| wr_en | input | 1 | Register write enable |
| wr_kind | input | 2 | Register kind: 0 index, 1 modify, 2 length, 3 base |
| wr_set | input | SW | Set written |
| wr_data | input | AW | Write data |
| addr0 | output | AW | Generator 0 address (current index) |
| addr1 | output | AW | Generator 1 address (current index) |
| nidx0 | output | AW | Generator 0 advanced, wrapped index |
| nidx1 | output | AW | Generator 1 advanced, wrapped index |

## Verification
The bench builds the block with its defaults: AW of 32, four sets and wrap logic enabled. The 32-bit width makes negative immediates wrap modulo 2^32 before the window test, which exercises the lower-bound correction. Four sets allow one set to have a nonzero length while another has a zero length with a large base, so linear and circular stepping run side by side. The bench also uses a shared set for the collision and write-override cases and a set whose sum lands exactly on the window's end.

// File: rtl/agen_pkg.sv
package agen_pkg;
   typedef enum logic [1:0] {
      REG_IDX  = 2'd0,
      REG_MOD  = 2'd1,
      REG_LEN  = 2'd2,
      REG_BASE = 2'd3
   } agen_reg_e;
endpackage

// File: rtl/agen_regfile.sv
module agen_regfile #(
   parameter int AW    = 32,
   parameter int NSETS = 4,
   parameter int SW    = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [1:0]    wr_kind,
   input  logic [SW-1:0] wr_set,
   input  logic [AW-1:0] wr_data,
   input  logic          upd0_en,
   input  logic [SW-1:0] upd0_set,
   input  logic [AW-1:0] upd0_val,
   input  logic          upd1_en,
   input  logic [SW-1:0] upd1_set,
   input  logic [AW-1:0] upd1_val,
   input  logic [SW-1:0] rd0_set,
   input  logic [SW-1:0] rd1_set,
   output logic [AW-1:0] rd0_idx,
   output logic [AW-1:0] rd0_mod,
   output logic [AW-1:0] rd0_len,
   output logic [AW-1:0] rd0_base,
   output logic [AW-1:0] rd1_idx,
   output logic [AW-1:0] rd1_mod,
   output logic [AW-1:0] rd1_len,
   output logic [AW-1:0] rd1_base
);
   import agen_pkg::*;

   logic [AW-1:0] idx_arr  [NSETS];
   logic [AW-1:0] mod_arr  [NSETS];
   logic [AW-1:0] len_arr  [NSETS];
   logic [AW-1:0] base_arr [NSETS];

   for (genvar g = 0; g < NSETS; g++) begin : g_set
      localparam logic [SW-1:0] MY = SW'(g);
      logic [AW-1:0] idx_q, mod_q, len_q, base_q;
      logic          hit;
      assign hit = wr_en && (wr_set == MY);

      // priority: register write, then generator 0, then generator 1
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            idx_q <= '0;
         end else if (hit && wr_kind == REG_IDX) begin
            idx_q <= wr_data;
         end else if (upd0_en && upd0_set == MY) begin
            idx_q <= upd0_val;
         end else if (upd1_en && upd1_set == MY) begin
            idx_q <= upd1_val;
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            mod_q  <= '0;
            len_q  <= '0;
            base_q <= '0;
         end else if (hit) begin
            if (wr_kind == REG_MOD)  mod_q  <= wr_data;
            if (wr_kind == REG_LEN)  len_q  <= wr_data;
            if (wr_kind == REG_BASE) base_q <= wr_data;
         end
      end

      assign idx_arr[g]  = idx_q;
      assign mod_arr[g]  = mod_q;
      assign len_arr[g]  = len_q;
      assign base_arr[g] = base_q;
   end

   assign rd0_idx  = idx_arr[rd0_set];
   assign rd0_mod  = mod_arr[rd0_set];
   assign rd0_len  = len_arr[rd0_set];
   assign rd0_base = base_arr[rd0_set];
   assign rd1_idx  = idx_arr[rd1_set];
   assign rd1_mod  = mod_arr[rd1_set];
   assign rd1_len  = len_arr[rd1_set];
   assign rd1_base = base_arr[rd1_set];
endmodule

// File: rtl/agen_step.sv
module agen_step #(
   parameter int AW      = 32,
   parameter bit WRAP_EN = 1'b1
) (
   input  logic [AW-1:0] cur_idx,
   input  logic [AW-1:0] step,
   input  logic [AW-1:0] len,
   input  logic [AW-1:0] base,
   output logic [AW-1:0] nxt
);
   logic [AW-1:0] sum;
   assign sum = cur_idx + step;

   if (WRAP_EN) begin : g_circ
      logic [AW:0] win_end;
      assign win_end = {1'b0, base} + {1'b0, len};
      always_comb begin
         nxt = sum;
         if (len != '0) begin
            if ({1'b0, sum} >= win_end) nxt = sum - len;
            else if (sum < base)        nxt = sum + len;
         end
      end
   end else begin : g_lin
      logic unused_win;
      assign unused_win = ^{len, base};
      assign nxt = sum;
   end
endmodule

// File: rtl/dual_circ_agen.sv
module dual_circ_agen #(
   parameter int AW      = 32,
   parameter int NSETS   = 4,
   parameter bit WRAP_EN = 1'b1,
   localparam int SW     = (NSETS > 1) ? $clog2(NSETS) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req0_valid,
   input  logic [SW-1:0] req0_set,
   input  logic          req0_use_imm,
   input  logic [AW-1:0] req0_imm,
   input  logic          req0_postmod,
   input  logic          req1_valid,
   input  logic [SW-1:0] req1_set,
   input  logic          req1_use_imm,
   input  logic [AW-1:0] req1_imm,
   input  logic          req1_postmod,
   input  logic          wr_en,
   input  logic [1:0]    wr_kind,
   input  logic [SW-1:0] wr_set,
   input  logic [AW-1:0] wr_data,
   output logic [AW-1:0] addr0,
   output logic [AW-1:0] addr1,
   output logic [AW-1:0] nidx0,
   output logic [AW-1:0] nidx1
);
   if (AW < 8) begin : g_bad_aw
      $error("dual_circ_agen: AW must be at least 8");
   end
   if (NSETS < 2 || (NSETS & (NSETS - 1)) != 0) begin : g_bad_sets
      $error("dual_circ_agen: NSETS must be a power of two, at least 2");
   end

   localparam int NGEN = 2;

   logic [SW-1:0] sel    [NGEN];
   logic          useimm [NGEN];
   logic [AW-1:0] imm    [NGEN];
   logic [AW-1:0] r_idx  [NGEN];
   logic [AW-1:0] r_mod  [NGEN];
   logic [AW-1:0] r_len  [NGEN];
   logic [AW-1:0] r_base [NGEN];
   logic [AW-1:0] nxt    [NGEN];

   assign sel[0]    = req0_set;
   assign sel[1]    = req1_set;
   assign useimm[0] = req0_use_imm;
   assign useimm[1] = req1_use_imm;
   assign imm[0]    = req0_imm;
   assign imm[1]    = req1_imm;

   agen_regfile #(.AW(AW), .NSETS(NSETS), .SW(SW)) u_rf (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_kind  (wr_kind),
      .wr_set   (wr_set),
      .wr_data  (wr_data),
      .upd0_en  (req0_valid && req0_postmod),
      .upd0_set (req0_set),
      .upd0_val (nxt[0]),
      .upd1_en  (req1_valid && req1_postmod),
      .upd1_set (req1_set),
      .upd1_val (nxt[1]),
      .rd0_set  (sel[0]),
      .rd1_set  (sel[1]),
      .rd0_idx  (r_idx[0]),
      .rd0_mod  (r_mod[0]),
      .rd0_len  (r_len[0]),
      .rd0_base (r_base[0]),
      .rd1_idx  (r_idx[1]),
      .rd1_mod  (r_mod[1]),
      .rd1_len  (r_len[1]),
      .rd1_base (r_base[1])
   );

   for (genvar k = 0; k < NGEN; k++) begin : g_gen
      logic [AW-1:0] step;
      assign step = useimm[k] ? imm[k] : r_mod[k];
      agen_step #(.AW(AW), .WRAP_EN(WRAP_EN)) u_step (
         .cur_idx (r_idx[k]),
         .step    (step),
         .len     (r_len[k]),
         .base    (r_base[k]),
         .nxt     (nxt[k])
      );
   end

   assign addr0 = r_idx[0];
   assign addr1 = r_idx[1];
   assign nidx0 = nxt[0];
   assign nidx1 = nxt[1];
endmodule

// File: rtl/agen_checker.sv
module agen_checker #(
   parameter int AW    = 32,
   parameter int NSETS = 4,
   localparam int SW   = (NSETS > 1) ? $clog2(NSETS) : 1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req0_valid,
   input logic [SW-1:0] req0_set,
   input logic          req0_postmod,
   input logic          req1_valid,
   input logic [SW-1:0] req1_set,
   input logic          req1_postmod,
   input logic          wr_en,
   input logic [1:0]    wr_kind,
   input logic [SW-1:0] wr_set,
   input logic [AW-1:0] wr_data,
   input logic [AW-1:0] addr0,
   input logic [AW-1:0] addr1,
   input logic [AW-1:0] nidx0
);
   logic pm0, pm1, wi0;
   assign pm0 = req0_valid && req0_postmod;
   assign pm1 = req1_valid && req1_postmod;
   assign wi0 = wr_en && (wr_kind == 2'd0) && (wr_set == req0_set);

   // R3: a post-update from generator 0 shows up as its next address
   p_postmod_adv_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (pm0 && !wi0) |=> ((req0_set != $past(req0_set)) || (addr0 == $past(nidx0))));

   // R8: generator 0 result wins when both update one set
   p_collide_g0_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pm0 && pm1 && req0_set == req1_set && !wi0)
      |=> ((req1_set != $past(req1_set)) || (addr1 == $past(nidx0))));

   // R9: index write lands next cycle and beats any post-update
   p_wr_prio_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_kind == 2'd0)
      |=> ((req0_set != $past(wr_set)) || (addr0 == $past(wr_data))));

   // R7: untouched index holds its value
   p_hold_idx_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!pm0 && !(pm1 && req1_set == req0_set) && !wi0)
      |=> ((req0_set != $past(req0_set)) || $stable(addr0)));
endmodule

bind dual_circ_agen agen_checker #(.AW(AW), .NSETS(NSETS)) u_chk (.*);

// File: tb/tb_dual_circ_agen.sv
module tb_dual_circ_agen;
   localparam int AW = 32;
   localparam int NSETS = 4;
   localparam int SW = 2;
   localparam time PERIOD = 10ns;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic          req0_valid = 0, req0_use_imm = 0, req0_postmod = 0;
   logic [SW-1:0] req0_set = '0;
   logic [AW-1:0] req0_imm = '0;
   logic          req1_valid = 0, req1_use_imm = 0, req1_postmod = 0;
   logic [SW-1:0] req1_set = '0;
   logic [AW-1:0] req1_imm = '0;
   logic          wr_en = 0;
   logic [1:0]    wr_kind = '0;
   logic [SW-1:0] wr_set = '0;
   logic [AW-1:0] wr_data = '0;
   logic [AW-1:0] addr0, addr1, nidx0, nidx1;

   dual_circ_agen #(.AW(AW), .NSETS(NSETS), .WRAP_EN(1'b1)) dut (.*);

   always #(PERIOD/2) clk = ~clk;

   typedef struct {
      string         tag;
      int            gen;
      logic [AW-1:0] a;
      logic [AW-1:0] n;
   } exp_t;
   exp_t q[$];

   int checks = 0, errors = 0;
   bit done = 0;

   logic [AW-1:0] mI [NSETS];
   logic [AW-1:0] mM [NSETS];
   logic [AW-1:0] mL [NSETS];
   logic [AW-1:0] mB [NSETS];

   function automatic logic [AW-1:0] ref_next(int s, bit ui, logic [AW-1:0] im);
      logic [AW-1:0] sum;
      sum = mI[s] + (ui ? im : mM[s]);
      if (mL[s] != 0) begin
         if ({1'b0, sum} >= ({1'b0, mB[s]} + {1'b0, mL[s]})) sum = sum - mL[s];
         else if (sum < mB[s]) sum = sum + mL[s];
      end
      return sum;
   endfunction

   // monitor: compare outputs mid-cycle against queued expectations
   always @(negedge clk) begin
      while (q.size() > 0) begin
         exp_t e;
         logic [AW-1:0] ga, gn;
         e = q.pop_front();
         ga = (e.gen == 0) ? addr0 : addr1;
         gn = (e.gen == 0) ? nidx0 : nidx1;
         checks++;
         if (ga !== e.a || gn !== e.n) begin
            errors++;
            $display("FAIL %s gen%0d addr=%h nidx=%h expected addr=%h nidx=%h",
                     e.tag, e.gen, ga, gn, e.a, e.n);
         end
      end
   end

   task automatic drive(input bit v0, input int s0, input bit i0, input logic [AW-1:0] m0,
                        input bit p0, input bit v1, input int s1, input bit i1,
                        input logic [AW-1:0] m1, input bit p1, input bit we, input int wk,
                        input int ws, input logic [AW-1:0] wd, input string tag);
      logic [AW-1:0] n0, n1;
      req0_valid = v0; req0_set = SW'(s0); req0_use_imm = i0; req0_imm = m0; req0_postmod = p0;
      req1_valid = v1; req1_set = SW'(s1); req1_use_imm = i1; req1_imm = m1; req1_postmod = p1;
      wr_en = we; wr_kind = 2'(wk); wr_set = SW'(ws); wr_data = wd;
      n0 = ref_next(s0, i0, m0);
      n1 = ref_next(s1, i1, m1);
      q.push_back('{tag, 0, mI[s0], n0});
      q.push_back('{tag, 1, mI[s1], n1});
      if (v1 && p1) mI[s1] = n1;
      if (v0 && p0) mI[s0] = n0;
      if (we) begin
         case (wk)
            0: mI[ws] = wd;
            1: mM[ws] = wd;
            2: mL[ws] = wd;
            default: mB[ws] = wd;
         endcase
      end
      @(posedge clk);
      #1;
   endtask

   task automatic wr(input int k, input int s, input logic [AW-1:0] d, input string tag);
      drive(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 1, k, s, d, tag);
   endtask

   task automatic idle(input int s0, input int s1, input string tag);
      drive(0, s0, 0, 0, 0, 0, s1, 0, 0, 0, 0, 0, 0, 0, tag);
   endtask

   initial begin
      #(PERIOD * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < NSETS; i++) begin
         mI[i] = '0; mM[i] = '0; mL[i] = '0; mB[i] = '0;
      end
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      idle(0, 3, "R1");
      // set 0: circular window 96..111, step 4; write visible next cycle only
      wr(0, 0, 32'd100, "R9");
      wr(1, 0, 32'd4, "R9");
      wr(2, 0, 32'd16, "R9");
      wr(3, 0, 32'd96, "R9");
      drive(1, 0, 0, 0, 1, 0, 1, 0, 0, 0, 0, 0, 0, 0, "R3");
      drive(1, 0, 0, 0, 1, 0, 1, 0, 0, 0, 0, 0, 0, 0, "R3");
      drive(1, 0, 0, 0, 1, 0, 1, 0, 0, 0, 0, 0, 0, 0, "R4");
      drive(1, 0, 1, -32'sd8, 1, 0, 1, 0, 0, 0, 0, 0, 0, 0, "R5");
      // set 1: linear, large base ignored
      wr(0, 1, 32'd1000, "R6");
      wr(1, 1, -32'sd4, "R6");
      wr(3, 1, 32'd2000, "R6");
      drive(1, 0, 0, 0, 1, 1, 1, 0, 0, 1, 0, 0, 0, 0, "R2 R6");
      drive(0, 0, 0, 0, 0, 1, 1, 1, 32'h10, 1, 0, 0, 0, 0, "R6");
      // no update when postmod clear or valid low
      drive(1, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, "R7");
      idle(0, 1, "R7");
      // set 2: collision, generator 0 wins
      wr(0, 2, 32'd500, "R8");
      wr(1, 2, 32'd1, "R8");
      drive(1, 2, 0, 0, 1, 1, 2, 1, 32'd100, 1, 0, 0, 0, 0, "R8");
      idle(2, 2, "R8");
      // modify write in the same cycle is not used yet
      drive(1, 2, 0, 0, 1, 0, 0, 0, 0, 0, 1, 1, 2, 32'd50, "R9");
      // index write overrides post-update
      drive(1, 2, 0, 0, 1, 1, 2, 0, 0, 1, 1, 0, 2, 32'd777, "R9");
      idle(2, 2, "R9");
      // set 3: exact window edges
      wr(3, 3, 32'h1000, "R4");
      wr(2, 3, 32'd8, "R4");
      wr(1, 3, 32'd1, "R4");
      wr(0, 3, 32'h1007, "R4");
      drive(1, 3, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R4");
      drive(0, 0, 0, 0, 0, 1, 3, 1, -32'sd1, 1, 0, 0, 0, 0, "R5");
      idle(3, 3, "R5");
      repeat (2) @(posedge clk);
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule